// File: doc/BRIEF.md
# Idle-State Coordination and Demotion Unit

This unit resolves low-power idle requests in two steps: from hardware threads to a state per core, then from the cores to one package state. Each thread presents a requested idle level as a 3-bit code and may receive a wake event. The unit keeps a registered state for every thread and every core. The package state and the C1E indication are decoded combinationally from the core states and the configuration inputs.

At every level the shallowest state wins. A thread or core that is idle must return to C0 before it can move to another idle level. The package has no such rule. Package C3 and C6 need a platform permission input. The enhanced C1 level (C1E) is reported when it is enabled and no core is running. A per-core residency history can demote deep requests until the core has shown idle periods long enough to justify the deeper level. The two demotion options are enabled independently.

Top module: `idle_state_coord`

## Requirements
- R1: State codes are C0=0, C1=1, C1E=2, C3=3, C6=6. A request is rounded to a supported level (2→1; 4 and 5→3; 7→6). A thread in C0 takes its rounded request at the next clock edge.
- R2: A thread in a non-C0 state keeps that state until its request returns to C0, then goes to C0. It never moves directly to another idle level.
- R3: A wake event on a thread puts that thread in C0 at the next edge, whatever its request. Its core is therefore C0 after the same edge.
- R4: A core enters the shallowest state among its threads. A demoted core may be shallower than that state, but never deeper. `core_state` packs core c at bits [3c+2:3c].
- R5: A core in a non-C0 state holds it until its shallowest thread reaches C0. It then goes to C0.
- R6: With no C1E and full permission, the package state is the shallowest core state, and it may move directly between idle levels.
- R7: While `plat_deep_ok` is 0, the package reports C1, or C1E if C1E is enabled, in place of C3 or C6.
- R8: When `c1e_en` is set and every core is non-C0, `c1e_active` is 1. Every core in C1 is then reported as code 2, and a C1-level package is reported as 2.
- R9: With only `dem_to_c3_en` set and no history, a core about to enter C6 enters C3.
- R10: With `dem_to_c1_en` set and no history, a core about to enter C3 or C6 enters C1. This option takes priority over `dem_to_c3_en`.
- R11: History is updated when a core leaves idle. It becomes set if the core was non-C0 for more than `res_thresh` cycles and cleared otherwise. While history is set, no demotion happens.
- R12: After reset, all thread states and core states are C0, the history is clear, the package is C0 and `c1e_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_req | input | NCORE*NTHR*3 | Idle request per thread; thread i at [3i+2:3i]; core c owns threads c*NTHR.. |
| thr_wake | input | NCORE*NTHR | Wake event per thread |
| c1e_en | input | 1 | Enable C1E reporting |
| dem_to_c3_en | input | 1 | Enable demotion of C6 to C3 |
| dem_to_c1_en | input | 1 | Enable demotion of C3 and C6 to C1 |
| res_thresh | input | RES_W | Residency threshold in cycles |
| plat_deep_ok | input | 1 | Platform allows package C3/C6 |
| core_state | output | NCORE*3 | Reported state per core |
| pkg_state | output | 3 | Reported package state |
| c1e_active | output | 1 | C1E condition met |

## Verification
The hardest condition to reach is a demotion decision that depends on history. That history was set or cleared by the length of an earlier idle period, under a threshold that may since have changed. Directed sequences first clear the history with a one-cycle idle period. They then hold a C6 request for ten cycles against a threshold of five and re-enter C6, which exercises both demotion options and the case where demotion is lifted. Random blocks keep requests steady over long runs so that idle periods of many lengths cross randomly chosen thresholds. A cycle model in the bench follows every transition.

// File: rtl/idle_state_coord.sv
module idle_state_coord #(
  parameter int NCORE = 2,
  parameter int NTHR  = 2,
  parameter int RES_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCORE*NTHR*3-1:0] thr_req,
  input  logic [NCORE*NTHR-1:0]   thr_wake,
  input  logic                    c1e_en,
  input  logic                    dem_to_c3_en,
  input  logic                    dem_to_c1_en,
  input  logic [RES_W-1:0]        res_thresh,
  input  logic                    plat_deep_ok,
  output logic [NCORE*3-1:0]      core_state,
  output logic [2:0]              pkg_state,
  output logic                    c1e_active
);
  localparam int NT = NCORE * NTHR;
  localparam logic [RES_W-1:0] CNT_MAX = '1;

  function automatic logic [2:0] legal(input logic [2:0] c);
    case (c)
      3'd0:             legal = 3'd0;
      3'd1, 3'd2:       legal = 3'd1;
      3'd3, 3'd4, 3'd5: legal = 3'd3;
      default:          legal = 3'd6;
    endcase
  endfunction

  logic [2:0]       thr_st [NT];
  logic [2:0]       thr_nx [NT];
  logic [2:0]       core_st [NCORE];
  logic [2:0]       core_nx [NCORE];
  logic [2:0]       core_tgt [NCORE];
  logic [RES_W-1:0] res_cnt [NCORE];
  logic             hist [NCORE];
  logic             all_idle;
  logic [2:0]       pkg_min;

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      if (thr_wake[i])                       thr_nx[i] = 3'd0;
      else if (thr_st[i] == 3'd0)            thr_nx[i] = legal(thr_req[3*i +: 3]);
      else if (legal(thr_req[3*i +: 3]) == 3'd0) thr_nx[i] = 3'd0;
      else                                   thr_nx[i] = thr_st[i];
    end
  end

  always_comb begin
    for (int c = 0; c < NCORE; c++) begin
      core_tgt[c] = 3'd7;
      for (int t = 0; t < NTHR; t++)
        if (thr_nx[c*NTHR+t] < core_tgt[c]) core_tgt[c] = thr_nx[c*NTHR+t];
      if (core_tgt[c] == 3'd0)                        core_nx[c] = 3'd0;
      else if (core_st[c] != 3'd0)                    core_nx[c] = core_st[c];
      else if (hist[c])                               core_nx[c] = core_tgt[c];
      else if (dem_to_c1_en && core_tgt[c] >= 3'd3)   core_nx[c] = 3'd1;
      else if (dem_to_c3_en && core_tgt[c] == 3'd6)   core_nx[c] = 3'd3;
      else                                            core_nx[c] = core_tgt[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) thr_st[i] <= 3'd0;
      for (int c = 0; c < NCORE; c++) begin
        core_st[c] <= 3'd0;
        res_cnt[c] <= '0;
        hist[c]    <= 1'b0;
      end
    end else begin
      for (int i = 0; i < NT; i++) thr_st[i] <= thr_nx[i];
      for (int c = 0; c < NCORE; c++) begin
        core_st[c] <= core_nx[c];
        if (core_st[c] != 3'd0) begin
          if (core_nx[c] == 3'd0) begin
            hist[c]    <= (res_cnt[c] >= res_thresh);
            res_cnt[c] <= '0;
          end else if (res_cnt[c] != CNT_MAX) begin
            res_cnt[c] <= res_cnt[c] + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    all_idle = 1'b1;
    pkg_min  = 3'd7;
    for (int c = 0; c < NCORE; c++) begin
      if (core_st[c] == 3'd0) all_idle = 1'b0;
      if (core_st[c] < pkg_min) pkg_min = core_st[c];
    end
  end

  assign c1e_active = c1e_en & all_idle;

  always_comb begin
    for (int c = 0; c < NCORE; c++)
      core_state[3*c +: 3] = (core_st[c] == 3'd1 && c1e_active) ? 3'd2 : core_st[c];
    if (pkg_min == 3'd0)                        pkg_state = 3'd0;
    else if (pkg_min >= 3'd3 && plat_deep_ok)   pkg_state = pkg_min;
    else                                        pkg_state = c1e_active ? 3'd2 : 3'd1;
  end

  genvar gt, gc, gk;
  generate
    for (gt = 0; gt < NT; gt++) begin : g_thr_chk
      p_thr_via_c0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_st[gt] != 3'd0) |=> (thr_st[gt] == $past(thr_st[gt]) || thr_st[gt] == 3'd0));
      p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wake[gt] |=> (thr_st[gt] == 3'd0 && core_st[gt/NTHR] == 3'd0));
    end
    for (gc = 0; gc < NCORE; gc++) begin : g_core_chk
      p_core_via_c0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_st[gc] != 3'd0) |=> (core_st[gc] == $past(core_st[gc]) || core_st[gc] == 3'd0));
      for (gk = 0; gk < NTHR; gk++) begin : g_shallow
        p_core_shallow_r4: assert property (@(posedge clk) disable iff (!rst_n)
          core_st[gc] <= thr_st[gc*NTHR+gk]);
      end
    end
  endgenerate

  p_pkg_perm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !plat_deep_ok |-> (pkg_state < 3'd3));
  p_c1e_r8: assert property (@(posedge clk) disable iff (!rst_n)
    c1e_active |-> (pkg_state != 3'd0 && c1e_en));
endmodule

// File: tb/idle_state_coord_tb_top.sv
module idle_state_coord_tb_top;
  localparam int NC = 2, NTH = 2, RW = 12, NT = NC * NTH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT*3-1:0] thr_req = '0;
  logic [NT-1:0]   thr_wake = '0;
  logic c1e_en = 0, dem_to_c3_en = 0, dem_to_c1_en = 0, plat_deep_ok = 0;
  logic [RW-1:0] res_thresh = '0;
  logic [NC*3-1:0] core_state;
  logic [2:0] pkg_state;
  logic c1e_active;

  int nchk = 0, nfail = 0;
  bit done = 0;
  int m_thr [NT];
  int m_core [NC];
  int m_cnt [NC];
  bit m_hist [NC];

  always #2.5 clk = ~clk;

  idle_state_coord #(.NCORE(NC), .NTHR(NTH), .RES_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .thr_req(thr_req), .thr_wake(thr_wake),
    .c1e_en(c1e_en), .dem_to_c3_en(dem_to_c3_en), .dem_to_c1_en(dem_to_c1_en),
    .res_thresh(res_thresh), .plat_deep_ok(plat_deep_ok),
    .core_state(core_state), .pkg_state(pkg_state), .c1e_active(c1e_active));

  function automatic int rnd(input int c);
    if (c == 0) return 0;
    if (c <= 2) return 1;
    if (c <= 5) return 3;
    return 6;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int nx [NT];
    for (int i = 0; i < NT; i++) begin
      int r = rnd(int'(thr_req[3*i +: 3]));
      if (thr_wake[i]) nx[i] = 0;
      else if (m_thr[i] == 0) nx[i] = r;
      else if (r == 0) nx[i] = 0;
      else nx[i] = m_thr[i];
    end
    for (int c = 0; c < NC; c++) begin
      int tgt = 7, cn;
      for (int t = 0; t < NTH; t++) if (nx[c*NTH+t] < tgt) tgt = nx[c*NTH+t];
      if (tgt == 0) cn = 0;
      else if (m_core[c] != 0) cn = m_core[c];
      else if (m_hist[c]) cn = tgt;
      else if (dem_to_c1_en && tgt >= 3) cn = 1;
      else if (dem_to_c3_en && tgt == 6) cn = 3;
      else cn = tgt;
      if (m_core[c] != 0) begin
        if (cn == 0) begin m_hist[c] = (m_cnt[c] >= int'(res_thresh)); m_cnt[c] = 0; end
        else if (m_cnt[c] < (1 << RW) - 1) m_cnt[c]++;
      end
      m_core[c] = cn;
    end
    for (int i = 0; i < NT; i++) m_thr[i] = nx[i];
  endtask

  task automatic compare(input string tag);
    bit idle = 1;
    int mn = 7, ep;
    bit ea;
    for (int c = 0; c < NC; c++) begin
      if (m_core[c] == 0) idle = 0;
      if (m_core[c] < mn) mn = m_core[c];
    end
    ea = c1e_en && idle;
    for (int c = 0; c < NC; c++)
      chk({tag, " core"}, int'(core_state[3*c +: 3]), (m_core[c] == 1 && ea) ? 2 : m_core[c]);
    if (mn == 0) ep = 0;
    else if (mn >= 3 && plat_deep_ok) ep = mn;
    else ep = ea ? 2 : 1;
    chk({tag, " pkg"}, int'(pkg_state), ep);
    chk({tag, " c1e"}, int'(c1e_active), int'(ea));
  endtask

  task automatic cyc(input string tag);
    model_step();
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic all_req(input int v);
    for (int i = 0; i < NT; i++) thr_req[3*i +: 3] = 3'(v);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NT; i++) m_thr[i] = 0;
    for (int c = 0; c < NC; c++) begin m_core[c] = 0; m_cnt[c] = 0; m_hist[c] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset core", int'(core_state), 0);
    chk("R12 reset pkg", int'(pkg_state), 0);
    chk("R12 reset c1e", int'(c1e_active), 0);
    rst_n = 1'b1;

    plat_deep_ok = 1; all_req(6); cyc("R4 R6 all C6");
    chk("R4 cores C6", int'(core_state), 6'o66);
    chk("R6 pkg C6", int'(pkg_state), 6);
    plat_deep_ok = 0; cyc("R7 no permission");
    chk("R7 pkg limited", int'(pkg_state), 1);
    thr_wake[0] = 1; cyc("R3 wake");
    chk("R3 core0 woken", int'(core_state), 6'o60);
    chk("R3 pkg C0", int'(pkg_state), 0);
    thr_wake[0] = 0; cyc("R1 re-enter");
    chk("R1 core0 back to C6", int'(core_state), 6'o66);
    all_req(0); cyc("R5 exit");
    thr_req[2:0] = 3'd2; thr_req[5:3] = 3'd7; cyc("R1 rounding");
    chk("R1 R4 core0 shallowest", int'(core_state), 6'o01);
    thr_req[2:0] = 3'd3; cyc("R2 hold");
    chk("R2 thread holds C1", int'(core_state), 6'o01);
    all_req(0); cyc("R2 exit");
    c1e_en = 1; all_req(1); cyc("R8 c1e");
    chk("R8 cores C1E", int'(core_state), 6'o22);
    chk("R8 pkg C1E", int'(pkg_state), 2);
    chk("R8 active", int'(c1e_active), 1);
    all_req(0); cyc("R8 exit");
    c1e_en = 0; plat_deep_ok = 1; res_thresh = 12'd5; dem_to_c3_en = 1;
    all_req(1); cyc("R11 short"); all_req(0); cyc("R11 short exit");
    all_req(6); cyc("R9 demote");
    chk("R9 C6 to C3", int'(core_state), 6'o33);
    for (int k = 0; k < 9; k++) cyc("R9 hold");
    all_req(0); cyc("R11 long exit");
    all_req(6); cyc("R11 history");
    chk("R11 no demotion", int'(core_state), 6'o66);
    all_req(0); cyc("R11 short exit2");
    dem_to_c1_en = 1; all_req(6); cyc("R10 demote");
    chk("R10 C6 to C1", int'(core_state), 6'o11);
    all_req(0); cyc("R10 exit");

    for (int b = 0; b < 40; b++) begin
      c1e_en = $urandom % 2; dem_to_c3_en = $urandom % 2; dem_to_c1_en = ($urandom % 3) == 0;
      plat_deep_ok = $urandom % 2; res_thresh = RW'($urandom % 12);
      for (int k = 0; k < 80; k++) begin
        for (int i = 0; i < NT; i++) begin
          if ($urandom % 4 == 0) begin
            int r = $urandom % 8;
            thr_req[3*i +: 3] = (r < 3) ? 3'd0 : 3'(r);
          end
          thr_wake[i] = ($urandom % 20) == 0;
        end
        if ($urandom % 10 == 0) plat_deep_ok = ~plat_deep_ok;
        cyc("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule